// File: doc/BRIEF.md
# Shared-Bus Arbiter with Tenure and Wait Timers

This block is the central arbiter for a shared bus with up to four masters. Each master raises its request line and gets a one-hot grant. Only one master owns the bus at any time. A new grant is issued only when nobody owns the bus and the bus is signalled idle.

Two counters bound how long one master can keep the bus while others wait.

- **Tenure timer.** It is loaded from the new owner's slot value at every grant and counts down on every owned cycle. When it reaches zero and another master is requesting, the owner is pushed off.
- **Wait timer.** It counts the cycles during which some other master has been waiting. Once it reaches the selected limit, the owner is pushed off even if tenure remains.

Each forced removal produces a one-cycle pulse that names its cause. Arbitration order is either fixed or rotating.

Top module: `bus_tenure_arbiter`

## Requirements
- R1: After reset, all grants are low, both pulses are low, and the rotation pointer is set so that master 0 is first in rotating order.
- R2: A grant is issued only on the clock edge after a cycle that has no grant, `bus_idle_i` high and at least one request. Grants are always one-hot or zero.
- R3: With `rotate_i`=0, the requesting master with the lowest index wins.
- R4: With `rotate_i`=1, the winner is the first requester above the most recently granted index, wrapping from N-1 to 0. The pointer follows every grant.
- R5: If the owner drops its request, its grant is removed at the next clock edge and no pulse is produced.
- R6: The tenure limit T is loaded at each grant and decrements once per owned cycle, stopping at zero. Consider a cycle in which the count is zero and another master requests. The grant is removed at the next edge and `expire_o` is high for exactly the first cycle without a grant. If others wait throughout, the owner holds the bus for T+1 cycles.
- R7: A tenure value of 0 lets the owner keep the bus for a single cycle whenever another master is requesting.
- R8: While no other master requests, the owner keeps its grant indefinitely. Once the count reaches zero it stays at zero, so a later request forces a handover at the next edge.
- R9: Slot s reads its tenure from `ten_cfg_i[s*10 +: 10]`. When `ten_dflt_i[s]`=1, the value 64 is used instead. Programmed values above 640 act as 640.
- R10: `pre_sel_i` selects the wait limit P.
  - The codes 1 to 7 give P = 5, 12, 20, 36, 68, 132 and 260.
  - Code 0 disables the wait timer.
  - The count is cleared at each grant and in any owned cycle with no other requester.
  - If the tenure count is not zero, the grant is removed at the edge that ends the P-th consecutive waiting cycle, and `preempt_o` pulses for one cycle.
  - If tenure expiry and the wait limit fall in the same cycle, `expire_o` pulses instead.
- R11: Every change of owner passes through at least one cycle with no grant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_i | input | N | Per-master request lines |
| ten_cfg_i | input | N*TW | Per-slot tenure values, slot s at bits s*TW and up |
| ten_dflt_i | input | N | Per-slot flag that forces the default tenure |
| pre_sel_i | input | 3 | Wait-limit code, where 0 means no preemption |
| rotate_i | input | 1 | 1 selects rotating priority, 0 selects fixed priority |
| bus_idle_i | input | 1 | Bus is idle, so a new grant may start |
| gnt_o | output | N | One-hot grant lines |
| expire_o | output | 1 | One-cycle pulse when a tenure expiry removes a grant |
| preempt_o | output | 1 | One-cycle pulse when the wait limit removes a grant |

## Verification
Every decision takes exactly one register stage. A grant, a removal and its pulse all appear one clock edge after the input cycle that causes them. A freshly granted owner therefore shows its grant T+1 samples before the first empty cycle.

The bench applies inputs on the falling edge and advances a requirement-level model by one edge. It then compares grants and pulses on the next falling edge. Hold lengths are counted in those samples, so the directed cases expect 1, 4, 14, 65 and 641 cycles exactly.

// File: rtl/bus_tenure_arbiter.sv
module bus_tenure_arbiter #(
  parameter int N        = 4,
  parameter int TW       = 10,
  parameter int TEN_DFLT = 64,
  parameter int TEN_MAX  = 640
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  req_i,
  input  logic [N*TW-1:0] ten_cfg_i,
  input  logic [N-1:0]  ten_dflt_i,
  input  logic [2:0]    pre_sel_i,
  input  logic          rotate_i,
  input  logic          bus_idle_i,
  output logic [N-1:0]  gnt_o,
  output logic          expire_o,
  output logic          preempt_o
);
  localparam int IW = (N > 1) ? $clog2(N) : 1;
  localparam int PW = 9;

  logic [IW-1:0] own_q, last_q, win;
  logic          win_ok;
  logic [TW-1:0] ten_q, ten_lim, cfg_w;
  logic [PW-1:0] pre_q, pre_lim;

  wire [N-1:0] others  = req_i & ~gnt_o;
  wire         waiting = |others;
  wire         owned   = |gnt_o;

  always_comb begin
    win    = '0;
    win_ok = 1'b0;
    for (int k = 0; k < N; k++) begin
      if (!win_ok && req_i[rotate_i ? (int'(last_q) + 1 + k) % N : k]) begin
        win_ok = 1'b1;
        win    = IW'(rotate_i ? (int'(last_q) + 1 + k) % N : k);
      end
    end
  end

  assign cfg_w = ten_cfg_i[int'(win)*TW +: TW];

  always_comb begin
    if (ten_dflt_i[win])              ten_lim = TW'(TEN_DFLT);
    else if (int'(cfg_w) > TEN_MAX)   ten_lim = TW'(TEN_MAX);
    else                              ten_lim = cfg_w;
  end

  always_comb begin
    case (pre_sel_i)
      3'd1:    pre_lim = PW'(5);
      3'd2:    pre_lim = PW'(12);
      3'd3:    pre_lim = PW'(20);
      3'd4:    pre_lim = PW'(36);
      3'd5:    pre_lim = PW'(68);
      3'd6:    pre_lim = PW'(132);
      3'd7:    pre_lim = PW'(260);
      default: pre_lim = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gnt_o     <= '0;
      own_q     <= '0;
      last_q    <= IW'(N - 1);
      ten_q     <= '0;
      pre_q     <= '0;
      expire_o  <= 1'b0;
      preempt_o <= 1'b0;
    end else begin
      expire_o  <= 1'b0;
      preempt_o <= 1'b0;
      if (!owned) begin
        pre_q <= '0;
        if (bus_idle_i && win_ok) begin
          gnt_o  <= N'(1) << win;
          own_q  <= win;
          last_q <= win;
          ten_q  <= ten_lim;
        end
      end else if (!req_i[own_q]) begin
        gnt_o <= '0;
      end else if (waiting && ten_q == '0) begin
        gnt_o    <= '0;
        expire_o <= 1'b1;
      end else if (waiting && pre_lim != '0 && pre_q >= pre_lim - PW'(1)) begin
        gnt_o     <= '0;
        preempt_o <= 1'b1;
      end else begin
        if (ten_q != '0) ten_q <= ten_q - TW'(1);
        pre_q <= waiting ? pre_q + PW'(1) : '0;
      end
    end
  end

  AST_GNT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gnt_o)); // R2
  AST_IDLE_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    (!owned && !bus_idle_i) |=> (gnt_o == '0)); // R2
  AST_HANDOVER_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    owned |=> (gnt_o == $past(gnt_o) || gnt_o == '0)); // R11
  AST_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (owned && (req_i & gnt_o) == '0) |=> (gnt_o == '0 && !expire_o && !preempt_o)); // R5
  AST_KEEP_ALONE: assert property (@(posedge clk) disable iff (!rst_n)
    (owned && (req_i & gnt_o) != '0 && !waiting) |=> (gnt_o == $past(gnt_o))); // R8
  AST_PULSE_NO_GNT: assert property (@(posedge clk) disable iff (!rst_n)
    (expire_o || preempt_o) |-> (gnt_o == '0 && !(expire_o && preempt_o))); // R6
endmodule

// File: tb/bus_tenure_arbiter_tb_top.sv
module bus_tenure_arbiter_tb_top;
  localparam int N = 4;
  localparam int TW = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [N-1:0] req = '0, dflt = '0;
  logic [N*TW-1:0] cfg = '0;
  logic [2:0] sel = '0;
  logic rot = 1'b0, idle = 1'b1;
  logic [N-1:0] gnt;
  logic exp_o, prm_o;

  always #2.5 clk = ~clk;

  bus_tenure_arbiter dut_i (
    .clk(clk), .rst_n(rst_n), .req_i(req), .ten_cfg_i(cfg), .ten_dflt_i(dflt),
    .pre_sel_i(sel), .rotate_i(rot), .bus_idle_i(idle),
    .gnt_o(gnt), .expire_o(exp_o), .preempt_o(prm_o));

  int checks = 0, failures = 0, cyc = 0;
  logic [N-1:0] m_gnt;
  int m_own, m_last, m_ten, m_pre;
  logic m_exp, m_prm;
  logic [N-1:0] prev_g;
  int run, last_run;
  logic seen_exp, seen_prm;

  always @(posedge clk) begin
    cyc++;
    if (cyc > 190000) begin
      failures++;
      $display("FAIL R2 watchdog expired actual=%0d expected=<190000", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int expv);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  function automatic int tlim(input int s);
    int v;
    v = int'(cfg[s*TW +: TW]);
    if (dflt[s]) return 64;
    if (v > 640) return 640;
    return v;
  endfunction

  function automatic int plim(input int s);
    case (s)
      1: return 5;
      2: return 12;
      3: return 20;
      4: return 36;
      5: return 68;
      6: return 132;
      7: return 260;
      default: return 0;
    endcase
  endfunction

  task automatic model_tick();
    logic [N-1:0] oth;
    int w, p;
    oth = req & ~m_gnt;
    p = plim(int'(sel));
    m_exp = 1'b0;
    m_prm = 1'b0;
    if (m_gnt == '0) begin
      m_pre = 0;
      w = -1;
      for (int k = 0; k < N; k++) begin
        int j;
        j = rot ? (m_last + 1 + k) % N : k;
        if (w < 0 && req[j]) w = j;
      end
      if (idle && w >= 0) begin
        m_gnt = N'(1) << w;
        m_own = w;
        m_last = w;
        m_ten = tlim(w);
      end
    end else if (!req[m_own]) begin
      m_gnt = '0;
    end else if (oth != '0 && m_ten == 0) begin
      m_gnt = '0;
      m_exp = 1'b1;
    end else if (oth != '0 && p != 0 && m_pre >= p - 1) begin
      m_gnt = '0;
      m_prm = 1'b1;
    end else begin
      if (m_ten != 0) m_ten--;
      m_pre = (oth != '0) ? m_pre + 1 : 0;
    end
  endtask

  task automatic step(input string tag);
    model_tick();
    @(negedge clk);
    check(gnt == m_gnt, tag, int'(gnt), int'(m_gnt));
    check(exp_o == m_exp && prm_o == m_prm, tag, {exp_o, prm_o}, {m_exp, m_prm});
    if (exp_o) seen_exp = 1'b1;
    if (prm_o) seen_prm = 1'b1;
    if (gnt != '0 && gnt == prev_g) begin
      run++;
    end else begin
      if (prev_g != '0) last_run = run;
      run = (gnt != '0) ? 1 : 0;
    end
    prev_g = gnt;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    req = '0; dflt = '0; cfg = '0; sel = '0; rot = 1'b0; idle = 1'b1;
    repeat (3) @(negedge clk);
    m_gnt = '0; m_own = 0; m_last = N - 1; m_ten = 0; m_pre = 0;
    m_exp = 1'b0; m_prm = 1'b0;
    prev_g = '0; run = 0; last_run = -1;
    seen_exp = 1'b0; seen_prm = 1'b0;
    rst_n = 1'b1;
  endtask

  initial begin
    void'($urandom(32'd20240611));

    do_reset();
    check(gnt == '0 && !exp_o && !prm_o, "R1 reset state", int'(gnt), 0);

    // R3 and R6: fixed priority, tenure 3 against a waiter
    cfg[0*TW +: TW] = 10'd3;
    req = 4'b0011;
    step("R3");
    check(gnt == 4'b0001, "R3 lowest index wins", int'(gnt), 1);
    repeat (6) step("R6");
    check(last_run == 4, "R6 tenure hold T+1", last_run, 4);
    check(seen_exp == 1'b1, "R6 expire pulse", int'(seen_exp), 1);

    // R7: tenure zero
    do_reset();
    req = 4'b0011;
    repeat (4) step("R7");
    check(last_run == 1, "R7 tenure zero hold", last_run, 1);

    // R9: default flag overrides programmed value
    do_reset();
    cfg[0*TW +: TW] = 10'd3;
    dflt[0] = 1'b1;
    req = 4'b0011;
    repeat (70) step("R9");
    check(last_run == 65, "R9 default tenure", last_run, 65);

    // R9 and R10: clipping, with preemption disabled
    do_reset();
    cfg[0*TW +: TW] = 10'd1000;
    req = 4'b0011;
    repeat (650) step("R9");
    check(last_run == 641, "R9 clip 640 with R10 no preempt", last_run, 641);

    // R10: wait limit 5
    do_reset();
    cfg[0*TW +: TW] = 10'd640;
    sel = 3'd1;
    req = 4'b0001;
    repeat (10) step("R10");
    req = 4'b0011;
    repeat (6) step("R10");
    check(last_run == 14, "R10 preempt after 5 waits", last_run, 14);
    check(seen_prm == 1'b1 && seen_exp == 1'b0, "R10 preempt pulse",
          {seen_prm, seen_exp}, 2);

    // R8: an owner alone keeps the grant, then yields at once
    do_reset();
    cfg[0*TW +: TW] = 10'd2;
    req = 4'b0001;
    repeat (20) step("R8");
    check(gnt == 4'b0001, "R8 keeps grant alone", int'(gnt), 1);
    req = 4'b0011;
    step("R8");
    check(gnt == 4'b0000 && exp_o, "R8 saturated count yields", int'({gnt, exp_o}), 1);

    // R4: rotating order
    do_reset();
    rot = 1'b1;
    req = 4'b1111;
    step("R4");
    check(gnt == 4'b0001, "R4 first grant", int'(gnt), 1);
    step("R11");
    check(gnt == 4'b0000, "R11 gap cycle", int'(gnt), 0);
    step("R4");
    check(gnt == 4'b0010, "R4 rotate next", int'(gnt), 2);
    repeat (12) step("R4");

    // R2 and R5: the idle gate, then a voluntary release
    do_reset();
    idle = 1'b0;
    req = 4'b0100;
    repeat (5) step("R2");
    check(gnt == '0, "R2 no grant while busy", int'(gnt), 0);
    idle = 1'b1;
    step("R2");
    check(gnt == 4'b0100, "R2 grant when idle", int'(gnt), 4);
    req = 4'b0000;
    step("R5");
    check(gnt == '0 && !exp_o && !prm_o, "R5 release", int'(gnt), 0);

    // Random run, checked in lockstep with the model
    do_reset();
    for (int s = 0; s < N; s++) cfg[s*TW +: TW] = TW'($urandom_range(0, 24));
    for (int i = 0; i < 4000; i++) begin
      if (i % 250 == 0) sel = 3'($urandom_range(0, 3));
      if (i % 600 == 0) rot = 1'($urandom_range(0, 1));
      if (i % 400 == 0) dflt = 4'($urandom_range(0, 15)) & 4'b0001;
      for (int b = 0; b < N; b++) if ($urandom_range(0, 7) == 0) req[b] = ~req[b];
      idle = ($urandom_range(0, 4) != 0);
      step(rot ? "R4 random" : "R3 random");
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule